// File: doc/BRIEF.md
# Segmented Thermometer-to-Binary Encoder

This block turns the raw decision vector of a bank of clocked comparators into a binary sample. The 256-bit vector is a thermometer code: comparator k reports 1 when the sampled input lies above the k-th reference, and bit 0 belongs to the lowest reference. The vector is split into four 64-bit columns. A separate encoder stage handles each column, and a merge stage turns the column results into one 8-bit value plus an overrange flag.

The input vector is captured on the rising clock edge. Each column encoder result is held in a 7-bit column latch on the falling edge: one "column full" flag and a 6-bit position. The merge stage and the output inversion run ahead of the output register, which loads on the next rising edge. A sample therefore appears exactly one clock after it was captured. Two control inputs flip the top output bit and the lower seven output bits. These controls travel through the pipeline with the sample they were captured with. A data-ready strobe shows that the pipeline holds a valid result.

Top module: `therm_seg_enc`

## Requirements
- R1: While rst_ni is low, data_o, ovr_o and valid_o are all 0.
- R2: For a clean code with comp_i[k]=1 for all k<n and 0 otherwise (0 ≤ n ≤ 255), data_o equals n when both inversion controls are 0.
- R3: Column c covers comp_i[64c+63:64c], and its top bit comp_i[64c+63] is its full flag. data_o[7:6] equals the index of the lowest column whose full flag is clear.
- R4: The inputs present at a rising edge produce their result at data_o and ovr_o at the following rising edge, and a new result is produced every cycle.
- R5: When all four column full flags are set, ovr_o is 1 and the uninverted data is 8'hFF. Otherwise ovr_o is 0.
- R6: Bubbles are resolved inside the active column. data_o[5:0] is one plus the index of the highest set bit among that column's lower 63 bits, or 0 if none of them is set.
- R7: msb_inv_i=1 flips data_o[7] and no other bit.
- R8: lsb_inv_i=1 flips data_o[6:0] and leaves data_o[7] alone.
- R9: The inversion controls have the same latency as comp_i, and they never change ovr_o.
- R10: valid_o stays 0 after reset release until the second rising edge, and then stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| comp_i | input | 256 | Comparator decisions, bit 0 = lowest reference |
| msb_inv_i | input | 1 | Invert the top output bit |
| lsb_inv_i | input | 1 | Invert the lower seven output bits |
| data_o | output | 8 | Encoded sample |
| ovr_o | output | 1 | Overrange flag |
| valid_o | output | 1 | Data-ready strobe |

## Verification
Overrange saturation and output inversion can act on the same sample. The all-ones result is forced first and then flipped by one or both controls. The bench provokes this by driving a full vector with each inversion setting on consecutive cycles. It expects the inverted saturation pattern on data_o while ovr_o stays high. The same cycles also show that each control arrives in step with its own sample and not with its neighbour's sample.

// File: rtl/therm_seg_pkg.sv
package therm_seg_pkg;
  localparam int unsigned DEF_NCOL = 4;
  localparam int unsigned DEF_CW   = 64;

  typedef struct packed {
    logic msb;
    logic lsb;
  } inv_ctl_t;
endpackage

// File: rtl/therm_col_enc.sv
module therm_col_enc #(
  parameter int unsigned CW = 64,
  localparam int unsigned PW = $clog2(CW)
) (
  input  logic [CW-1:0] bits_i,
  output logic          full_o,
  output logic [PW-1:0] pos_o
);
  assign full_o = bits_i[CW-1];

  // highest set bit below the top wins; resolves bubbles
  always_comb begin
    pos_o = '0;
    for (int i = 0; i < int'(CW) - 1; i++) begin
      if (bits_i[i]) pos_o = PW'(i + 1);
    end
  end
endmodule

// File: rtl/therm_col_merge.sv
module therm_col_merge #(
  parameter int unsigned NCOL = 4,
  parameter int unsigned PW   = 6,
  localparam int unsigned CSW = $clog2(NCOL),
  localparam int unsigned OW  = CSW + PW
) (
  input  logic [NCOL-1:0]         full_i,
  input  logic [NCOL-1:0][PW-1:0] pos_i,
  output logic [OW-1:0]           code_o,
  output logic                    ovr_o
);
  logic [CSW-1:0] act;

  // lowest non-full column is active
  always_comb begin
    act   = '0;
    ovr_o = 1'b1;
    for (int c = int'(NCOL) - 1; c >= 0; c--) begin
      if (!full_i[c]) begin
        act   = CSW'(c);
        ovr_o = 1'b0;
      end
    end
  end

  assign code_o = ovr_o ? '1 : {act, pos_i[act]};
endmodule

// File: rtl/therm_out_stage.sv
module therm_out_stage
  import therm_seg_pkg::*;
#(
  parameter int unsigned OW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [OW-1:0] code_i,
  input  logic          ovr_i,
  input  inv_ctl_t      inv_i,
  input  logic          vld_i,
  output logic [OW-1:0] data_o,
  output logic          ovr_o,
  output logic          valid_o
);
  logic [OW-1:0] flip;

  assign flip = {inv_i.msb, {(OW-1){inv_i.lsb}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      ovr_o   <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      data_o  <= code_i ^ flip;
      ovr_o   <= ovr_i;
      valid_o <= vld_i;
    end
  end
endmodule

// File: rtl/therm_seg_enc.sv
module therm_seg_enc
  import therm_seg_pkg::*;
#(
  parameter int unsigned NCOL = DEF_NCOL,
  parameter int unsigned CW   = DEF_CW,
  localparam int unsigned TW  = NCOL * CW,
  localparam int unsigned PW  = $clog2(CW),
  localparam int unsigned OW  = $clog2(NCOL) + PW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] comp_i,
  input  logic          msb_inv_i,
  input  logic          lsb_inv_i,
  output logic [OW-1:0] data_o,
  output logic          ovr_o,
  output logic          valid_o
);
  // rising-edge capture
  logic [TW-1:0] comp_q;
  inv_ctl_t      inv_q;
  logic          cap_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      comp_q <= '0;
      inv_q  <= '0;
      cap_v  <= 1'b0;
    end else begin
      comp_q <= comp_i;
      inv_q  <= '{msb: msb_inv_i, lsb: lsb_inv_i};
      cap_v  <= 1'b1;
    end
  end

  // column encoders and falling-edge column latches
  logic [NCOL-1:0]         full_c, full_l;
  logic [NCOL-1:0][PW-1:0] pos_c,  pos_l;
  inv_ctl_t                inv_l;
  logic                    lat_v;

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    therm_col_enc #(.CW(CW)) u_enc (
      .bits_i (comp_q[c*CW +: CW]),
      .full_o (full_c[c]),
      .pos_o  (pos_c[c])
    );

    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        full_l[c] <= 1'b0;
        pos_l[c]  <= '0;
      end else begin
        full_l[c] <= full_c[c];
        pos_l[c]  <= pos_c[c];
      end
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inv_l <= '0;
      lat_v <= 1'b0;
    end else begin
      inv_l <= inv_q;
      lat_v <= cap_v;
    end
  end

  logic [OW-1:0] code;
  logic          ovr;

  therm_col_merge #(.NCOL(NCOL), .PW(PW)) u_merge (
    .full_i (full_l),
    .pos_i  (pos_l),
    .code_o (code),
    .ovr_o  (ovr)
  );

  therm_out_stage #(.OW(OW)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .code_i  (code),
    .ovr_i   (ovr),
    .inv_i   (inv_l),
    .vld_i   (lat_v),
    .data_o  (data_o),
    .ovr_o   (ovr_o),
    .valid_o (valid_o)
  );
endmodule

// File: rtl/therm_seg_enc_chk.sv
module therm_seg_enc_chk #(
  parameter int unsigned NCOL = 4,
  parameter int unsigned CW   = 64,
  localparam int unsigned TW  = NCOL * CW,
  localparam int unsigned OW  = $clog2(NCOL) + $clog2(CW)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [TW-1:0] comp_i,
  input logic          msb_inv_i,
  input logic          lsb_inv_i,
  input logic [OW-1:0] data_o,
  input logic          ovr_o,
  input logic          valid_o
);
  logic [NCOL-1:0] tops;
  logic [OW-1:0]   flip;

  for (genvar c = 0; c < NCOL; c++) begin : g_top
    assign tops[c] = comp_i[c*CW + CW - 1];
  end

  assign flip = {msb_inv_i, {(OW-1){lsb_inv_i}}};

  p_ovr_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (ovr_o == (&$past(tops, 2))));

  p_ovr_sat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ovr_o) |-> (data_o == ~$past(flip, 2)));

  p_zero_code_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ($past(comp_i, 2) == '0)) |-> (data_o == $past(flip, 2)));

  p_col0_msb_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !$past(tops[0], 2)) |-> (data_o[OW-1:OW-2] == {$past(msb_inv_i, 2), $past(lsb_inv_i, 2)}));

  p_valid_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);
endmodule

bind therm_seg_enc therm_seg_enc_chk #(.NCOL(NCOL), .CW(CW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .comp_i    (comp_i),
  .msb_inv_i (msb_inv_i),
  .lsb_inv_i (lsb_inv_i),
  .data_o    (data_o),
  .ovr_o     (ovr_o),
  .valid_o   (valid_o)
);

// File: tb/sim_therm_seg_enc.sv
`timescale 1ns/1ps
module sim_therm_seg_enc;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [255:0] comp = '0;
  logic         minv = 1'b0;
  logic         linv = 1'b0;
  logic [7:0]   data;
  logic         ovr;
  logic         valid;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [8:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  therm_seg_enc u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .comp_i    (comp),
    .msb_inv_i (minv),
    .lsb_inv_i (linv),
    .data_o    (data),
    .ovr_o     (ovr),
    .valid_o   (valid)
  );

  function automatic logic [255:0] therm(input int n);
    logic [255:0] r;
    for (int k = 0; k < 256; k++) r[k] = (k < n);
    return r;
  endfunction

  // expected {ovr, data} from R3/R5/R6/R7/R8
  function automatic logic [8:0] model(input logic [255:0] v, input logic m, input logic l);
    int act;
    logic [7:0] d;
    int pos;
    act = -1;
    for (int c = 3; c >= 0; c--) if (!v[c*64+63]) act = c;
    if (act < 0) return {1'b1, 8'hFF ^ {m, {7{l}}}};
    pos = 0;
    for (int i = 0; i < 63; i++) if (v[act*64+i]) pos = i + 1;
    d = {act[1:0], pos[5:0]};
    return {1'b0, d ^ {m, {7{l}}}};
  endfunction

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, expv);
    end
  endtask

  task automatic drive(input logic [255:0] v, input logic m, input logic l, input string tag);
    comp = v;
    minv = m;
    linv = l;
    exp_q.push_back(model(v, m, l));
    tag_q.push_back(tag);
    @(posedge clk);
    #1;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && valid && exp_q.size() > 0) begin
        logic [8:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {ovr, data}, e);
      end
    end
  end

  initial begin
    logic [255:0] v;
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset data/ovr", {ovr, data}, 9'h000);
    check("R1 reset valid", {8'h00, valid}, 9'h000);
    @(negedge clk);
    rst_n = 1'b1;

    drive(therm(0), 1'b0, 1'b0, "R2 n=0");
    check("R10 valid low after first edge", {8'h00, valid}, 9'h000);
    drive(therm(1), 1'b0, 1'b0, "R2 n=1");
    check("R10 valid high after second edge", {8'h00, valid}, 9'h001);

    // R4: consecutive samples each cycle
    drive(therm(63),  1'b0, 1'b0, "R2 R4 n=63");
    drive(therm(64),  1'b0, 1'b0, "R3 n=64");
    drive(therm(65),  1'b0, 1'b0, "R3 n=65");
    drive(therm(127), 1'b0, 1'b0, "R3 n=127");
    drive(therm(128), 1'b0, 1'b0, "R3 n=128");
    drive(therm(191), 1'b0, 1'b0, "R3 n=191");
    drive(therm(192), 1'b0, 1'b0, "R3 n=192");
    drive(therm(200), 1'b0, 1'b0, "R2 n=200");
    drive(therm(255), 1'b0, 1'b0, "R2 R5 n=255 no ovr");
    drive(therm(256), 1'b0, 1'b0, "R5 overrange");
    drive(therm(37),  1'b0, 1'b0, "R4 back-to-back after ovr");

    // R6 bubbles
    v = therm(70); v[100] = 1'b1;
    drive(v, 1'b0, 1'b0, "R6 stray bit above in active column");
    v = therm(64); v[10] = 1'b0;
    drive(v, 1'b0, 1'b0, "R6 hole in full column");
    v = therm(63); v[5] = 1'b0;
    drive(v, 1'b0, 1'b0, "R6 hole below top");
    v = therm(64); v[65] = 1'b1; v[140] = 1'b1;
    drive(v, 1'b0, 1'b0, "R6 R3 stray bits in higher columns");
    v = '0; v[127] = 1'b1;
    drive(v, 1'b0, 1'b0, "R3 lowest non-full column chosen");

    // R7/R8 inversion
    drive(therm(150), 1'b1, 1'b0, "R7 msb invert");
    drive(therm(150), 1'b0, 1'b1, "R8 lsb invert");
    drive(therm(150), 1'b1, 1'b1, "R7 R8 both invert");
    drive(therm(0),   1'b0, 1'b1, "R8 zero code lsb invert");

    // R9 overrange with inversion, alternating per cycle
    drive(therm(256), 1'b1, 1'b0, "R9 ovr + msb invert");
    drive(therm(256), 1'b0, 1'b1, "R9 ovr + lsb invert");
    drive(therm(256), 1'b1, 1'b1, "R9 ovr + both invert");
    drive(therm(256), 1'b0, 1'b0, "R9 ovr no invert");
    drive(therm(20),  1'b1, 1'b0, "R9 control follows its sample");
    drive(therm(20),  1'b0, 1'b0, "R9 control released");

    comp = '0; minv = 1'b0; linv = 1'b0;
    repeat (4) @(posedge clk);
    #3;
    if (exp_q.size() != 0) check("R4 pending results", 9'(exp_q.size()), 9'h000);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule